// File: doc/BRIEF.md
# Descriptor-Chained Stream-to-Memory DMA Engine

This engine takes a byte stream with an end-of-packet marker from a client and writes it into memory buffers. Each buffer is described by a four-word data descriptor held in memory. The engine fills the current buffer one byte at a time. A descriptor is closed in two cases: its buffer is full, or the packet ends early. On closing, the engine writes the real fill point back into the descriptor, marks whether a packet ended there, and raises interrupt strobes. It then follows the descriptor's next pointer to the following buffer. When it closes a descriptor flagged as the last in the list, the channel stops taking data. At that point it writes the disable bit back into the context descriptor and drops any further bytes, recording the loss in a sticky overflow flag.

Software drives the engine with a small set of controls:
- A stream command loads the context descriptor, whose saved pointers give the data descriptor address and the current write position.
- A stream command loads the data descriptor and can also start the channel.
- A continue request restarts a channel that stopped at end of list, once software has cleared the end-of-list bit in that descriptor.

Memory is reached through a simple word read/write port with byte enables.

Top module: `dma_in_engine`

## Requirements
- R1: Each accepted byte is written with one write on the memory port. The write goes to the word holding the current position, with the single byte enable and data lane chosen by the position's low address bits. The position then advances by one.
- R2: A descriptor closes when the position reaches its end address (word 3). Word 2 (control) and then word 3 are written back, with word 3 holding the final position.
- R3: A descriptor also closes when a byte arrives with end-of-packet. Word 3 is then the address just past that byte. Control bit 14 is set in the written-back word, and interrupt strobe bit 3 pulses.
- R4: When control bit 4 of the closing descriptor is set, interrupt strobe bits 1 and 0 pulse together for one cycle.
- R5: A descriptor without end of list (control bit 0 clear) is followed by fetching the descriptor at its next pointer (word 0). The position is set to that descriptor's buffer start (word 1), and streaming resumes.
- R6: Closing a descriptor with control bit 0 set raises the end-of-list flag. Bit 15 is set in the context control word, which is written to context address plus 4. Later bytes are accepted but not written, and the sticky overflow flag is raised.
- R7: A continue request acts only when the channel is enabled, not stopped, running, and the loaded descriptor has end of list set. It refetches that descriptor. If end of list is now clear and the end-of-list flag is set, it fetches the next descriptor, moves the position to its buffer start, clears the flag and resumes. Otherwise nothing changes.
- R8: A command with bit 8 or bit 6 set fetches the data descriptor at the saved descriptor pointer. If bit 5 is also set, the channel starts. A command with bit 9 set fetches the eight-word context descriptor and takes word 6 as the descriptor pointer and word 7 as the position. When bits 9 and 8 or 6 are set together, the data fetch comes first.
- R9: While a descriptor is fetched or written back, the input is stalled (in_ready low) and no command or continue request is taken (cmd_ready low).
- R10: Clearing cfg_en or raising cfg_stop stops the channel, and in_ready stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable level |
| cfg_stop | input | 1 | Channel stop level |
| ctx_addr | input | AW | Byte address of the context descriptor |
| cmd_valid | input | 1 | Stream command present |
| cmd_code | input | 10 | Stream command bits |
| cmd_ready | output | 1 | Command or continue request can be taken this cycle |
| cont_req | input | 1 | Continue request, taken when cmd_ready is high |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_eop | input | 1 | Input byte is the last of its packet |
| in_ready | output | 1 | Input byte taken this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, one per accepted read |
| mem_rdata | input | DW | Read data |
| irq_set | output | 4 | One-cycle interrupt set strobes |
| chan_eol | output | 1 | Channel has reached end of list |
| chan_overflow | output | 1 | Sticky: a byte was dropped after end of list |

## Verification
A table of buffers is filled in several ways, each separating one closing cause from the others:
- a buffer filled exactly with no packet end;
- a packet ending well short of the end address;
- a packet end landing on the last byte, so both causes meet;
- a single-byte packet;
- an unaligned buffer start that crosses a word boundary.

Each pattern checks the written-back end address, the packet-end bit, the strobes and the written bytes, along with the bytes that must stay untouched. Directed runs then cover:
- a two-descriptor chain;
- bytes dropped after end of list;
- a continue request refused while end of list is still set, and then honoured;
- stop, and a load without start, which must leave the input stalled.

// File: rtl/din_pkg.sv
package din_pkg;
   // data descriptor control word bits
   localparam int CTL_EOL    = 0;
   localparam int CTL_INTR   = 4;
   localparam int CTL_INEOP  = 14;
   // context control word bit
   localparam int CTX_DIS    = 15;
   // stream command bits
   localparam int CMD_BURST  = 5;
   localparam int CMD_LDD_A  = 6;
   localparam int CMD_LDD_B  = 8;
   localparam int CMD_LDC    = 9;

   typedef enum logic [1:0] {S_READY, S_FETCH, S_WB, S_CWB} din_state_t;
   typedef enum logic [2:0] {W_LOADD, W_LOADC, W_NEXT, W_CONT1, W_CONT2} din_why_t;
endpackage

// File: rtl/din_lane_pack.sv
module din_lane_pack #(
   parameter int DW = 32,
   parameter int LB = $clog2(DW / 8)
) (
   input  logic [LB-1:0]     lane,
   input  logic [7:0]        data,
   output logic [DW-1:0]     wdata,
   output logic [DW/8-1:0]   be
);
   localparam int LANES = DW / 8;
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wdata[g*8 +: 8] = data;
      assign be[g]           = (lane == LB'(g));
   end
endmodule

// File: rtl/din_seq.sv
module din_seq
   import din_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int LB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_stop,
   input  logic [AW-1:0]     ctx_addr,
   input  logic              cmd_valid,
   input  logic [9:0]        cmd_code,
   output logic              cmd_ready,
   input  logic              cont_req,
   input  logic              in_valid,
   input  logic              in_eop,
   output logic              in_ready,
   output logic [LB-1:0]     pos_lane,
   input  logic [DW-1:0]     lane_wdata,
   input  logic [DW/8-1:0]   lane_be,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW/8-1:0]   mem_be,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata,
   output logic [3:0]        irq_set,
   output logic              chan_eol,
   output logic              chan_overflow
);
   din_state_t    st;
   din_why_t      why;
   logic [2:0]    idx;
   logic          pend, run, eolf, ovf, burst_pend, c_pend;
   logic [AW-1:0] sd, sdb, d_next, d_buf, d_after, base, pos_nx;
   logic [DW-1:0] d_ctrl, c_ctrl;
   logic          byte_go, byte_acc, done, last_word, cont_ok;
   logic          unused_cmd;

   assign unused_cmd = ^{cmd_code[7], cmd_code[4:0]};
   assign pos_lane   = sdb[LB-1:0];
   assign pos_nx     = sdb + AW'(1);
   assign done       = (pos_nx == d_after) || in_eop;
   assign base       = (why == W_LOADC) ? ctx_addr : sd;
   assign last_word  = (why == W_LOADC) ? (idx == 3'd7) : (idx == 3'd3);
   assign cont_ok    = cont_req && cfg_en && !cfg_stop && run && d_ctrl[CTL_EOL];
   assign byte_go    = (st == S_READY) && run && !eolf && in_valid;
   assign in_ready   = (st == S_READY) && run && (eolf || mem_gnt);
   assign byte_acc   = in_valid && in_ready;
   assign cmd_ready  = (st == S_READY) && !byte_acc;
   assign chan_eol   = eolf;
   assign chan_overflow = ovf;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      mem_be    = '0;
      unique case (st)
         S_FETCH: begin
            mem_req  = !pend;
            mem_addr = base + (AW'(idx) << 2);
         end
         S_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = '1;
            mem_addr  = sd + (idx[0] ? AW'(12) : AW'(8));
            mem_wdata = idx[0] ? DW'(d_after) : d_ctrl;
         end
         S_CWB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = '1;
            mem_addr  = ctx_addr + AW'(4);
            mem_wdata = c_ctrl | (DW'(1) << CTX_DIS);
         end
         default: begin
            if (byte_go) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = {sdb[AW-1:LB], LB'(0)};
               mem_wdata = lane_wdata;
               mem_be    = lane_be;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_READY;  why <= W_LOADD;  idx <= '0;  pend <= 1'b0;
         run <= 1'b0;  eolf <= 1'b0;  ovf <= 1'b0;
         burst_pend <= 1'b0;  c_pend <= 1'b0;
         sd <= '0;  sdb <= '0;  d_next <= '0;  d_buf <= '0;  d_after <= '0;
         d_ctrl <= '0;  c_ctrl <= '0;  irq_set <= '0;
      end else begin
         irq_set <= '0;
         unique case (st)
            S_FETCH: begin
               if (mem_req && mem_gnt) pend <= 1'b1;
               else if (pend && mem_rvalid) begin
                  pend <= 1'b0;
                  idx  <= idx + 3'd1;
                  if (why == W_LOADC) begin
                     if (idx == 3'd1) c_ctrl <= mem_rdata;
                     if (idx == 3'd6) sd     <= mem_rdata[AW-1:0];
                     if (idx == 3'd7) sdb    <= mem_rdata[AW-1:0];
                  end else begin
                     if (idx == 3'd0) d_next  <= mem_rdata[AW-1:0];
                     if (idx == 3'd1) d_buf   <= mem_rdata[AW-1:0];
                     if (idx == 3'd2) d_ctrl  <= mem_rdata;
                     if (idx == 3'd3) d_after <= mem_rdata[AW-1:0];
                  end
                  if (last_word) begin
                     idx <= '0;
                     st  <= S_READY;
                     unique case (why)
                        W_LOADD: begin
                           if (burst_pend) begin
                              run  <= 1'b1;
                              eolf <= 1'b0;
                           end
                           burst_pend <= 1'b0;
                           if (c_pend) begin
                              c_pend <= 1'b0;
                              why    <= W_LOADC;
                              st     <= S_FETCH;
                           end
                        end
                        W_NEXT: sdb <= d_buf;
                        W_CONT1: begin
                           if (!d_ctrl[CTL_EOL] && eolf) begin
                              sd  <= d_next;
                              why <= W_CONT2;
                              st  <= S_FETCH;
                           end
                        end
                        W_CONT2: begin
                           sdb  <= d_buf;
                           eolf <= 1'b0;
                        end
                        default: ;
                     endcase
                  end
               end
            end
            S_WB: begin
               if (mem_gnt) begin
                  if (!idx[0]) idx <= 3'd1;
                  else begin
                     idx <= '0;
                     if (d_ctrl[CTL_EOL]) begin
                        eolf <= 1'b1;
                        st   <= S_CWB;
                     end else begin
                        sd  <= d_next;
                        why <= W_NEXT;
                        st  <= S_FETCH;
                     end
                  end
               end
            end
            S_CWB: begin
               if (mem_gnt) begin
                  c_ctrl[CTX_DIS] <= 1'b1;
                  st <= S_READY;
               end
            end
            default: begin
               if (byte_acc) begin
                  if (eolf) ovf <= 1'b1;
                  else begin
                     sdb <= pos_nx;
                     if (done) begin
                        d_after <= pos_nx;
                        if (in_eop) d_ctrl[CTL_INEOP] <= 1'b1;
                        irq_set <= {in_eop, 1'b0, {2{d_ctrl[CTL_INTR]}}};
                        st <= S_WB;
                     end
                  end
               end else if (cmd_valid && (cmd_code[CMD_LDD_A] || cmd_code[CMD_LDD_B])) begin
                  why        <= W_LOADD;
                  burst_pend <= cmd_code[CMD_BURST];
                  c_pend     <= cmd_code[CMD_LDC];
                  st         <= S_FETCH;
               end else if (cmd_valid && cmd_code[CMD_LDC]) begin
                  why <= W_LOADC;
                  st  <= S_FETCH;
               end else if (cont_ok) begin
                  why <= W_CONT1;
                  st  <= S_FETCH;
               end
            end
         endcase
         if (!cfg_en || cfg_stop) run <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_in_engine.sv
module dma_in_engine #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_stop,
   input  logic [AW-1:0]     ctx_addr,
   input  logic              cmd_valid,
   input  logic [9:0]        cmd_code,
   output logic              cmd_ready,
   input  logic              cont_req,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_eop,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW/8-1:0]   mem_be,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata,
   output logic [3:0]        irq_set,
   output logic              chan_eol,
   output logic              chan_overflow
);
   localparam int LANES = DW / 8;
   localparam int LB    = $clog2(LANES);

   if (DW % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power-of-two count of at least two bytes");
   end
   if (AW > DW || AW < 8) begin : g_bad_aw
      $error("AW must lie between 8 and DW");
   end

   logic [LB-1:0]    pos_lane;
   logic [DW-1:0]    lane_wdata;
   logic [LANES-1:0] lane_be;

   din_lane_pack #(.DW(DW), .LB(LB)) u_pack (
      .lane(pos_lane), .data(in_data), .wdata(lane_wdata), .be(lane_be)
   );

   din_seq #(.AW(AW), .DW(DW), .LB(LB)) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_stop(cfg_stop),
      .ctx_addr(ctx_addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_ready(cmd_ready), .cont_req(cont_req), .in_valid(in_valid),
      .in_eop(in_eop), .in_ready(in_ready), .pos_lane(pos_lane),
      .lane_wdata(lane_wdata), .lane_be(lane_be), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .irq_set(irq_set), .chan_eol(chan_eol),
      .chan_overflow(chan_overflow)
   );
endmodule

// File: rtl/din_chk.sv
module din_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       cmd_ready,
   input logic       mem_req,
   input logic       mem_we,
   input logic [3:0] irq_set,
   input logic       chan_eol,
   input logic       chan_overflow
);
   logic unused_irq2;
   assign unused_irq2 = irq_set[2];

   assert_byte_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !chan_eol) |-> (mem_req && mem_we));
   assert_eop_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[3] |-> (mem_req && mem_we));
   assert_intr_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[0] |-> (irq_set[1] && mem_req && mem_we));
   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_overflow |=> chan_overflow);
   assert_eol_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_eol) |-> $past(mem_req && mem_we));
   assert_fetch_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (!in_ready && !cmd_ready));
endmodule

bind dma_in_engine din_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
   .irq_set(irq_set), .chan_eol(chan_eol), .chan_overflow(chan_overflow)
);

// File: tb/test_dma_in_engine.sv
`timescale 1ns/1ps
module test_dma_in_engine;
   localparam int AW = 32;
   localparam int DW = 32;
   // {off, len, nbytes, exp_irq[3:0], 2'b0, eop, intr}
   localparam logic [31:0] VEC [5] = '{
      {8'd0, 8'd4, 8'd4, 4'b0011, 2'b0, 1'b0, 1'b1},
      {8'd0, 8'd8, 8'd3, 4'b1000, 2'b0, 1'b1, 1'b0},
      {8'd0, 8'd5, 8'd5, 4'b1011, 2'b0, 1'b1, 1'b1},
      {8'd2, 8'd6, 8'd1, 4'b1011, 2'b0, 1'b1, 1'b1},
      {8'd3, 8'd5, 8'd5, 4'b0000, 2'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;
   logic rst_n = 1'b0, cfg_en = 1'b1, cfg_stop = 1'b0;
   logic [AW-1:0] ctx_addr = 32'h100;
   logic cmd_valid = 1'b0, cont_req = 1'b0, in_valid = 1'b0, in_eop = 1'b0;
   logic [9:0] cmd_code = '0;
   logic [7:0] in_data = '0;
   logic cmd_ready, in_ready, mem_req, mem_we, mem_rvalid = 1'b0;
   logic mem_gnt = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata = '0;
   logic [3:0] mem_be, irq_set, irq_seen = '0;
   logic chan_eol, chan_overflow, irq_clr = 1'b0;
   logic [31:0] mem [128];
   int ntests = 0, nfail = 0;

   dma_in_engine #(.AW(AW), .DW(DW)) i_dma_in_engine (.*);

   always @(posedge clk) begin
      mem_rvalid <= mem_req && mem_gnt && !mem_we;
      mem_rdata  <= mem[mem_addr[8:2]];
      if (mem_req && mem_gnt && mem_we)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[8:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      irq_seen <= irq_clr ? 4'b0 : (irq_seen | irq_set);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_byte(input int a);
      return mem[a >> 2][(a & 3) * 8 +: 8];
   endfunction

   task automatic do_cmd(input logic [9:0] c);
      cmd_valid = 1'b1; cmd_code = c;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_cont();
      cont_req = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cont_req = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, input logic e);
      in_valid = 1'b1; in_data = b; in_eop = e;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400 && !cmd_ready; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 128; k++) mem[k] = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset in_ready", in_ready, 0);
      check("R6 reset eol", chan_eol, 0);
      check("R6 reset overflow", chan_overflow, 0);
      check("R1 reset mem_req", mem_req, 0);
      check("R9 reset cmd_ready", cmd_ready, 1);

      for (int v = 0; v < 5; v++) begin
         logic [31:0] vec;
         int off, len, n, bad;
         vec = VEC[v]; off = vec[31:24]; len = vec[23:16]; n = vec[15:8];
         clear_mem();
         mem[0] = 32'h10; mem[1] = 32'h40 + off;
         mem[2] = 32'h1 | (32'(vec[0]) << 4); mem[3] = 32'h40 + off + len;
         mem[64 + 6] = 32'h0; mem[64 + 7] = 32'h40 + off;
         irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
         do_cmd(10'h200);
         do_cmd(10'h160);
         for (int i = 0; i < n; i++) send(8'(v * 16 + i + 1), vec[1] && (i == n - 1));
         wait_idle();
         check("R2 R3 after writeback", mem[3], 32'h40 + off + n);
         check("R3 in_eop bit", 32'(mem[2][14]), 32'(vec[1]));
         check("R4 R3 irq strobes", 32'(irq_seen), 32'(vec[7:4]));
         bad = 0;
         for (int i = 0; i < n; i++) if (rd_byte(32'h40 + off + i) != 8'(v * 16 + i + 1)) bad++;
         check("R1 R8 bytes at position", bad, 0);
         check("R1 byte past end untouched", rd_byte(32'h40 + off + n), 0);
         check("R6 eol flag", chan_eol, 1);
         check("R6 context disable", 32'(mem[65][15]), 1);
      end

      // chain of two descriptors
      clear_mem();
      mem[0] = 32'h10; mem[1] = 32'h40; mem[2] = 0; mem[3] = 32'h42;
      mem[4] = 32'h30; mem[5] = 32'h60; mem[6] = 1; mem[7] = 32'h62;
      mem[70] = 0; mem[71] = 32'h40;
      do_cmd(10'h200);
      do_cmd(10'h160);
      check("R9 stall during fetch in_ready", in_ready, 0);
      check("R9 stall during fetch cmd_ready", cmd_ready, 0);
      send(8'hAA, 0); send(8'hBB, 0); send(8'hCC, 0); send(8'hDD, 0);
      wait_idle();
      check("R5 chain bytes", {rd_byte(32'h40), rd_byte(32'h41), rd_byte(32'h60), rd_byte(32'h61)}, 32'hAABBCCDD);
      check("R2 first after", mem[3], 32'h42);
      check("R6 chain eol", chan_eol, 1);
      send(8'hEE, 0);
      check("R6 overflow", chan_overflow, 1);
      check("R6 dropped byte", rd_byte(32'h62), 0);

      // continue refused while end of list still set
      do_cont();
      wait_idle();
      check("R7 refused keeps eol", chan_eol, 1);
      // continue honoured
      mem[6] = 0; mem[4] = 32'h20;
      mem[8] = 32'h30; mem[9] = 32'h70; mem[10] = 1; mem[11] = 32'h71;
      do_cont();
      wait_idle();
      check("R7 continue clears eol", chan_eol, 0);
      send(8'h5A, 0);
      wait_idle();
      check("R7 byte after continue", rd_byte(32'h70), 32'h5A);
      check("R7 eol again", chan_eol, 1);
      check("R7 after of new descr", mem[11], 32'h71);

      // stop, then load without start
      cfg_stop = 1'b1; @(negedge clk);
      in_valid = 1'b1; @(negedge clk);
      check("R10 stopped in_ready", in_ready, 0);
      in_valid = 1'b0; cfg_stop = 1'b0;
      do_cmd(10'h140);
      wait_idle();
      in_valid = 1'b1; @(negedge clk);
      check("R8 load without start", in_ready, 0);
      in_valid = 1'b0;

      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule